// File: doc/BRIEF.md
# Addressed Three-Wire Serial Command Receiver

This block takes commands from a host over three wires: a select line, a serial clock and a serial data line. While select is low the host shifts a device address into the block; when select rises the block decides whether the last address it saw is its own. While select is high the host shifts instruction bits, which the block collects in arrival order. When select falls, a matching frame is handed to the rest of the chip as one instruction word with its bit count and a one-cycle valid strobe.

All three wires are asynchronous to the system clock. Each is brought through a synchronizer before any edge is detected. A separate run input gates the whole receiver, so the host link can be held off while the rest of the device is being initialized. The serial clock may rest either low or high between frames.

Top module: `s3w_cmd_rx`

## Requirements
- R1: A frame is accepted only if the last 8 bits shifted while select was low equal 0x47. The first of those 8 bits is bit 0 (LSB first).
- R2: While select is high, each rising edge of the serial clock stores the data bit. The k-th bit received (k counting from 0) lands in cmd_word[k]. Word bits that the frame did not reach read 0.
- R3: A frame stores at most 64 bits. Further bits are ignored, and cmd_len saturates at 64.
- R4: On the falling edge of select after an accepted frame, cmd_valid is high for exactly one system clock cycle, with cmd_word and cmd_len for that frame. At all other times cmd_word and cmd_len keep their values.
- R5: If a frame's address does not match, no cmd_valid pulse is issued and cmd_word and cmd_len keep their previous values.
- R6: Frames are received correctly whether the serial clock idles low or high between transfers.
- R7: While host_run is low, serial activity is ignored. A frame sent in that state gives no pulse, and a frame that is partly collected is dropped.
- R8: After the synchronous reset, cmd_valid, cmd_word and cmd_len are all 0.
- R9: Extra leading address bits are allowed. Only the final 8 address bits shifted before select rises take part in the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_run | input | 1 | Asynchronous enable for the serial link; low ignores all transfers |
| ser_sel | input | 1 | Asynchronous select: low during the address phase, high during the data phase |
| ser_clk | input | 1 | Asynchronous serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Asynchronous serial data, LSB first |
| cmd_valid | output | 1 | One-cycle strobe marking a new instruction |
| cmd_word | output | 64 | Received instruction bits, first bit in bit 0 |
| cmd_len | output | 7 | Number of data bits stored, 0 to 64 |

## Verification
The main path is driven with frames of 16, 24, 64 and 72 data bits, with the serial clock idling low in some and high in others. These patterns separate bit-order errors, idle-level sensitivity and missing saturation at 64 bits. A short frame sent right after a long one shows whether stale word bits are cleared. Two address patterns are used: 0x46, and the bit-reversed image 0xE2. Together they separate a correct LSB-first match from a match that is too loose or that shifts in the wrong direction. A frame with leading junk bits checks that only the last eight address bits count. A correct frame sent while host_run is low, followed by one sent after it returns high, shows that gating drops frames and then recovers.

// File: rtl/s3w_pkg.sv
package s3w_pkg;
  // Positions of the asynchronous inputs inside the synchronizer vector.
  localparam int SIG_DAT = 0;
  localparam int SIG_CLK = 1;
  localparam int SIG_SEL = 2;
  localparam int SIG_RUN = 3;
  localparam int SIG_NUM = 4;

  // Events derived from the synchronized serial wires.
  typedef struct packed {
    logic sel_lvl;
    logic sel_rise;
    logic sel_fall;
    logic sclk_rise;
    logic dat;
    logic run;
  } s3w_evt_t;
endpackage

// File: rtl/s3w_sync.sv
module s3w_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // One independent flop chain per input bit.
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/s3w_addr_match.sv
module s3w_addr_match #(
  parameter int           ADDR_W   = 8,
  parameter logic [7:0]   DEV_ADDR = 8'h47
) (
  input  logic clk,
  input  logic rst,
  input  s3w_pkg::s3w_evt_t ev,
  output logic hit
);
  logic [ADDR_W-1:0] shreg;

  // LSB first: new bits enter at the top and move down; the oldest of the last ADDR_W bits ends in bit 0.
  always_ff @(posedge clk) begin
    if (rst || !ev.run) begin
      shreg <= '0;
      hit   <= 1'b0;
    end else begin
      if (ev.sclk_rise && !ev.sel_lvl)
        shreg <= {ev.dat, shreg[ADDR_W-1:1]};
      if (ev.sel_rise)
        hit <= (shreg == ADDR_W'(DEV_ADDR));
    end
  end

  // R7: the link gate clears any earlier match
  p_gate_clears_hit_r7: assert property (@(posedge clk) disable iff (rst)
    !ev.run |=> !hit);
  // R1: a match can only turn on when select rises
  p_hit_rises_on_sel_r1: assert property (@(posedge clk) disable iff (rst)
    (!hit && !ev.sel_rise) |=> !hit);
endmodule

// File: rtl/s3w_data_acc.sv
module s3w_data_acc #(
  parameter int MAX_BITS = 64,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  s3w_pkg::s3w_evt_t   ev,
  input  logic                hit,
  output logic                cmd_valid,
  output logic [MAX_BITS-1:0] cmd_word,
  output logic [CNT_W-1:0]    cmd_len
);
  localparam int IDX_W = $clog2(MAX_BITS);

  logic [MAX_BITS-1:0] acc;
  logic [CNT_W-1:0]    cnt;
  logic                room;

  assign room = (cnt < CNT_W'(MAX_BITS));

  always_ff @(posedge clk) begin
    if (rst || !ev.run) begin
      acc <= '0;
      cnt <= '0;
    end else if (ev.sel_rise) begin
      acc <= '0;
      cnt <= '0;
    end else if (ev.sel_lvl && ev.sclk_rise && room) begin
      acc[cnt[IDX_W-1:0]] <= ev.dat;
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
      cmd_len   <= '0;
    end else begin
      cmd_valid <= ev.sel_fall && hit && ev.run;
      if (ev.sel_fall && hit && ev.run) begin
        cmd_word <= acc;
        cmd_len  <= cnt;
      end
    end
  end

  // R3: the bit counter never passes the word width
  p_cnt_cap_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_BITS));
  // R4: the strobe lasts a single cycle
  p_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R4: the outputs change only together with the strobe
  p_hold_word_r4: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> $stable(cmd_word) && $stable(cmd_len));
endmodule

// File: rtl/s3w_cmd_rx.sv
module s3w_cmd_rx #(
  parameter int         MAX_BITS    = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEV_ADDR    = 8'h47,
  parameter int         CNT_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_run,
  input  logic                ser_sel,
  input  logic                ser_clk,
  input  logic                ser_dat,
  output logic                cmd_valid,
  output logic [MAX_BITS-1:0] cmd_word,
  output logic [CNT_W-1:0]    cmd_len
);
  import s3w_pkg::*;

  logic [SIG_NUM-1:0] raw, syn;
  logic               sel_q, clk_q;
  s3w_evt_t           ev;
  logic               hit;

  always_comb begin
    raw          = '0;
    raw[SIG_DAT] = ser_dat;
    raw[SIG_CLK] = ser_clk;
    raw[SIG_SEL] = ser_sel;
    raw[SIG_RUN] = host_run;
  end

  s3w_sync #(.WIDTH(SIG_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .dout(syn)
  );

  // Edge detection on the synchronized select and serial clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      sel_q <= syn[SIG_SEL];
      clk_q <= syn[SIG_CLK];
    end
  end

  always_comb begin
    ev.sel_lvl   = syn[SIG_SEL];
    ev.sel_rise  = syn[SIG_SEL] & ~sel_q;
    ev.sel_fall  = ~syn[SIG_SEL] & sel_q;
    ev.sclk_rise = syn[SIG_CLK] & ~clk_q;
    ev.dat       = syn[SIG_DAT];
    ev.run       = syn[SIG_RUN];
  end

  s3w_addr_match #(.ADDR_W(8), .DEV_ADDR(DEV_ADDR)) u_addr (
    .clk(clk), .rst(rst), .ev(ev), .hit(hit)
  );

  s3w_data_acc #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .ev(ev), .hit(hit),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_len(cmd_len)
  );

  // R7: no strobe follows a cycle with the link gated off
  p_gated_silent_r7: assert property (@(posedge clk) disable iff (rst)
    !ev.run |=> !cmd_valid);
  // R3: a reported length never exceeds the word width
  p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_len <= CNT_W'(MAX_BITS));
endmodule

// File: tb/s3w_cmd_rx_tb.sv
module s3w_cmd_rx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_run = 1'b1;
  logic        ser_sel = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        cmd_valid;
  logic [63:0] cmd_word;
  logic [6:0]  cmd_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int          pulses;
  logic [63:0] got_word;
  logic [6:0]  got_len;

  always #10 clk = ~clk;

  s3w_cmd_rx u_dut (
    .clk(clk), .rst(rst), .host_run(host_run), .ser_sel(ser_sel),
    .ser_clk(ser_clk), .ser_dat(ser_dat),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_len(cmd_len)
  );

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  // One serial bit; the clock rests at idle_hi before and after.
  task automatic put_bit(input logic b, input bit idle_hi);
    if (idle_hi) begin
      ser_clk = 1'b0; ser_dat = b; half();
      ser_clk = 1'b1; half();
    end else begin
      ser_dat = b; half();
      ser_clk = 1'b1; half();
      ser_clk = 1'b0;
    end
  endtask

  // Sends a frame, then watches the outputs for a while after select falls.
  task automatic frame(input logic [15:0] addr, input int an, input logic [79:0] data,
                       input int dn, input bit idle_hi);
    ser_clk = idle_hi; ser_sel = 1'b0; half();
    for (int i = 0; i < an; i++) put_bit(addr[i], idle_hi);
    half(); ser_sel = 1'b1; half();
    for (int i = 0; i < dn; i++) put_bit(data[i], idle_hi);
    half(); ser_sel = 1'b0;
    pulses = 0;
    repeat (16) begin
      @(negedge clk);
      if (cmd_valid) begin
        pulses++;
        got_word = cmd_word;
        got_len  = cmd_len;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R8 valid", 80'(cmd_valid), 80'd0);
    chk(cmd_word == 64'd0, "R8 word", 80'(cmd_word), 80'd0);
    chk(cmd_len == 7'd0, "R8 len", 80'(cmd_len), 80'd0);
  endtask

  task automatic t_basic();
    frame(16'h0047, 8, 80'hA5C3, 16, 1'b0);
    chk(pulses == 1, "R4 R1 one pulse", 80'(pulses), 80'd1);
    chk(got_word == 64'hA5C3, "R2 word", 80'(got_word), 80'hA5C3);
    chk(got_len == 7'd16, "R4 len", 80'(got_len), 80'd16);
  endtask

  task automatic t_idle_high();
    frame(16'h0047, 8, 80'h3C_9E17, 24, 1'b1);
    chk(pulses == 1, "R6 pulse", 80'(pulses), 80'd1);
    chk(got_word == 64'h3C9E17, "R6 word", 80'(got_word), 80'h3C9E17);
    chk(got_len == 7'd24, "R6 len", 80'(got_len), 80'd24);
  endtask

  task automatic t_long();
    logic [79:0] d;
    d = 80'h5A_F0E1D2C3B4A59687;
    frame(16'h0047, 8, d, 64, 1'b0);
    chk(got_word == d[63:0] && pulses == 1, "R3 full 64", 80'(got_word), 80'(d[63:0]));
    chk(got_len == 7'd64, "R3 len 64", 80'(got_len), 80'd64);
    d = 80'hFF_123456789ABCDEF0;
    frame(16'h0047, 8, d, 72, 1'b1);
    chk(got_word == d[63:0], "R3 overflow ignored", 80'(got_word), 80'(d[63:0]));
    chk(got_len == 7'd64, "R3 len saturates", 80'(got_len), 80'd64);
  endtask

  task automatic t_short_after_long();
    frame(16'h0047, 8, 80'h5, 3, 1'b0);
    chk(got_word == 64'h5, "R2 stale bits cleared", 80'(got_word), 80'h5);
    chk(got_len == 7'd3, "R2 short len", 80'(got_len), 80'd3);
  endtask

  task automatic t_mismatch();
    frame(16'h0046, 8, 80'hFFFF, 16, 1'b0);
    chk(pulses == 0, "R5 wrong addr no pulse", 80'(pulses), 80'd0);
    chk(cmd_word == 64'h5 && cmd_len == 7'd3, "R5 outputs held", 80'(cmd_word), 80'h5);
    frame(16'h00E2, 8, 80'hFFFF, 16, 1'b1);
    chk(pulses == 0, "R1 reversed addr no pulse", 80'(pulses), 80'd0);
  endtask

  task automatic t_leading();
    frame(16'h047B, 12, 80'h81, 8, 1'b0);
    chk(pulses == 1 && got_word == 64'h81, "R9 last 8 bits match", 80'(got_word), 80'h81);
  endtask

  task automatic t_gate();
    host_run = 1'b0; half();
    frame(16'h0047, 8, 80'h1234, 16, 1'b0);
    chk(pulses == 0, "R7 gated no pulse", 80'(pulses), 80'd0);
    chk(cmd_word == 64'h81, "R7 word held", 80'(cmd_word), 80'h81);
    host_run = 1'b1; half();
    frame(16'h0047, 8, 80'h77, 8, 1'b1);
    chk(pulses == 1 && got_word == 64'h77, "R7 recovers", 80'(got_word), 80'h77);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    repeat (4) @(negedge clk);
    t_basic();
    t_idle_high();
    t_long();
    t_short_after_long();
    t_mismatch();
    t_leading();
    t_gate();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule